// File: doc/BRIEF.md
# Radar trigger echo packetizer

This block takes the digitized echo of a pulse radar, one trigger at a time, and turns it into fixed-size records in a packet buffer. A record holds a short header followed by the 8-bit echo samples taken after that trigger. The header carries the antenna azimuth, the antenna speed and the working mode, all captured on the trigger edge. Records are written one byte per cycle as an addressed write stream. Addresses start at zero at the start of each packet and rise by one for every byte written.

The working mode sets the sample count of a record: short-pulse, medium-pulse and long-pulse operation each have their own trigger length. The number of whole records in one packet is the largest count whose total size stays within the packet limit (64 KiB by default). The packet's mode is taken from its first trigger and holds until the packet is complete. When the last byte of the last record is written, a one-cycle completion pulse reports the packet's byte count, so the host can fetch the buffer.

A trigger that comes before the current record has all its samples ends that record early. The missing samples are written as zeros, and the header of the next record carries an overrun flag.

Top module: `radar_echo_packer`

## Requirements
- R1: While `rst` is high, and after it falls until the first accepted trigger, `wr_en` and `pkt_done` stay low. Triggers and samples presented during reset produce no write.
- R2: Each record starts with 7 header bytes at offsets 0 to 6: sync word high byte, sync word low byte, mode byte, azimuth high, azimuth low, speed high, speed low. Azimuth and speed are the `az_in` and `spd_in` values at the accepted trigger edge. The mode byte is {overrun, 5'b00000, mode code}.
- R3: After the header, the record holds one byte per accepted `smp_valid`, in arrival order. The record has LEN_SHORT samples for mode code 0, LEN_MED for code 1, and LEN_LONG for codes 2 and 3.
- R4: A sample is not written when it arrives after its record already holds its full sample count, or before the record's header is complete.
- R5: A packet holds n = floor(LIMIT / (L + 7)) whole records, where L is the packet's sample count. The records sit back to back from address 0. Each write goes to the address one above the previous write, and the address returns to 0 after a packet completes.
- R6: `pkt_done` is high for exactly one cycle, in the same cycle as the write of the packet's final byte. In that cycle `pkt_bytes` equals n * (L + 7), which is the final byte's address plus one.
- R7: The mode code and sample count of a packet come from its first trigger. A different `mode_in` at later triggers of the same packet changes neither the mode byte nor the record length.
- R8: A trigger that arrives while a record is still collecting samples fills the rest of that record with zero bytes. The next record's header then has the overrun bit (bit 7 of the mode byte) set. The record after that has the bit clear unless it was also cut short.
- R9: A trigger edge that arrives while a header or zero padding is being written is ignored.
- R10: `trig` is edge sensitive: a trigger held high for several cycles starts only one record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Radar trigger; a rising edge starts a record |
| smp_valid | input | 1 | Echo sample strobe |
| smp_data | input | 8 | Echo sample value |
| az_in | input | 16 | Antenna azimuth |
| spd_in | input | 16 | Antenna speed |
| mode_in | input | 2 | Working mode code: 0 short, 1 medium, 2 long, 3 long |
| wr_en | output | 1 | Packet buffer byte write strobe |
| wr_addr | output | $clog2(LIMIT+1) | Byte address within the packet |
| wr_data | output | 8 | Byte written |
| pkt_done | output | 1 | One-cycle packet complete pulse |
| pkt_bytes | output | $clog2(LIMIT+1) | Total bytes of the completed packet |

## Verification
The hardest conditions to reach are the cut-short records. The early trigger has to land while the record is still collecting samples, and the next record's samples have to arrive only after both the zero padding and the new header have been written. The stimulus counts the padding owed by the previous record and delays the next sample burst by that many cycles. One cut is made with two samples collected and another with none collected, so a whole record of zeros is written. The sequence runs to the end of the packet to show that the overrun flag appears only in the header that follows each cut.

// File: rtl/rep_pkg.sv
package rep_pkg;

  localparam int unsigned HDR_BYTES = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_SMP,
    ST_PAD
  } rep_state_e;

  typedef struct packed {
    logic [15:0] az;
    logic [15:0] spd;
    logic [1:0]  mode;
  } trig_info_t;

  // whole records of the given sample count that fit in the limit
  function automatic int unsigned recs_fit(input int unsigned limit,
                                           input int unsigned samples);
    return limit / (samples + HDR_BYTES);
  endfunction

  function automatic logic [7:0] mode_byte(input logic [1:0] mode,
                                           input logic ovr);
    return {ovr, 5'b00000, mode};
  endfunction

  // header byte at a given position within the record
  function automatic logic [7:0] hdr_byte(input logic [2:0]  idx,
                                          input logic [15:0] sync,
                                          input logic [7:0]  mb,
                                          input logic [15:0] az,
                                          input logic [15:0] spd);
    logic [7:0] b;
    case (idx)
      3'd0:    b = sync[15:8];
      3'd1:    b = sync[7:0];
      3'd2:    b = mb;
      3'd3:    b = az[15:8];
      3'd4:    b = az[7:0];
      3'd5:    b = spd[15:8];
      3'd6:    b = spd[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/rep_trig_latch.sv
module rep_trig_latch
  import rep_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        trig,
  input  logic        take,
  input  logic [15:0] az_in,
  input  logic [15:0] spd_in,
  input  logic [1:0]  mode_in,
  output logic        rise,
  output trig_info_t  info
);

  logic trig_q;

  assign rise = trig & ~trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b1;
      info   <= '0;
    end else begin
      trig_q <= trig;
      if (take) begin
        info.az   <= az_in;
        info.spd  <= spd_in;
        info.mode <= mode_in;
      end
    end
  end

endmodule

// File: rtl/rep_plan.sv
module rep_plan
  import rep_pkg::*;
#(
  parameter int unsigned LEN_SHORT = 512,
  parameter int unsigned LEN_MED   = 1024,
  parameter int unsigned LEN_LONG  = 2048,
  parameter int unsigned LIMIT     = 65536,
  parameter int unsigned CW        = 12,
  parameter int unsigned NW        = 7
) (
  input  logic [1:0]    mode,
  output logic [CW-1:0] samples,
  output logic [NW-1:0] recs
);

  logic [CW-1:0] len_tab [4];
  logic [NW-1:0] n_tab   [4];

  for (genvar g = 0; g < 4; g++) begin : g_mode
    localparam int unsigned L = (g == 0) ? LEN_SHORT :
                                (g == 1) ? LEN_MED   : LEN_LONG;
    assign len_tab[g] = CW'(L);
    assign n_tab[g]   = NW'(recs_fit(LIMIT, L));
  end

  assign samples = len_tab[mode];
  assign recs    = n_tab[mode];

endmodule

// File: rtl/rep_core.sv
module rep_core
  import rep_pkg::*;
#(
  parameter int unsigned CW   = 12,
  parameter int unsigned NW   = 7,
  parameter int unsigned AW   = 17,
  parameter logic [15:0] SYNC = 16'hA55A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_rise,
  input  trig_info_t    info,
  input  logic [CW-1:0] plan_len,
  input  logic [NW-1:0] plan_n,
  input  logic          smp_valid,
  input  logic [7:0]    smp_data,
  output logic          trig_take,
  output logic          pad_wr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          pkt_done,
  output logic [AW-1:0] pkt_bytes
);

  rep_state_e    state;
  logic [2:0]    hdr_idx;
  logic [CW-1:0] cnt;
  logic [NW-1:0] rec_cnt;
  logic [AW-1:0] ptr;
  logic [CW-1:0] pkt_len;
  logic [NW-1:0] pkt_n;
  logic [1:0]    pkt_mode;
  logic          ovr_next;

  logic       hdr_wr, smp_take, byte_wr;
  logic       last_body, last_rec, pkt_end, new_pkt, hdr_last;
  logic [7:0] hbyte;

  // named internal events
  assign trig_take = trig_rise && (state == ST_IDLE || state == ST_SMP);
  assign smp_take  = (state == ST_SMP) && smp_valid && !trig_take;
  assign pad_wr    = (state == ST_PAD);
  assign hdr_wr    = (state == ST_HDR);
  assign byte_wr   = hdr_wr || smp_take || pad_wr;
  assign hdr_last  = hdr_wr && (hdr_idx == 3'(HDR_BYTES - 1));
  assign last_body = (smp_take || pad_wr) && (cnt == pkt_len - CW'(1));
  assign last_rec  = (rec_cnt == pkt_n - NW'(1));
  assign pkt_end   = last_body && last_rec;
  assign new_pkt   = hdr_wr && (hdr_idx == 3'd0) && (rec_cnt == '0);

  assign hbyte = hdr_byte(hdr_idx, SYNC, mode_byte(pkt_mode, ovr_next),
                          info.az, info.spd);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hdr_idx   <= '0;
      cnt       <= '0;
      rec_cnt   <= '0;
      ptr       <= '0;
      pkt_len   <= '0;
      pkt_n     <= '0;
      pkt_mode  <= '0;
      ovr_next  <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      pkt_done  <= 1'b0;
      pkt_bytes <= '0;
    end else begin
      wr_en    <= byte_wr;
      pkt_done <= pkt_end;

      if (byte_wr) begin
        wr_addr <= ptr;
        if (hdr_wr)        wr_data <= hbyte;
        else if (smp_take) wr_data <= smp_data;
        else               wr_data <= 8'h00;
        ptr <= pkt_end ? '0 : ptr + AW'(1);
      end

      if (pkt_end) pkt_bytes <= ptr + AW'(1);

      if (new_pkt) begin
        pkt_mode <= info.mode;
        pkt_len  <= plan_len;
        pkt_n    <= plan_n;
      end

      if (last_body) rec_cnt <= last_rec ? '0 : rec_cnt + NW'(1);

      case (state)
        ST_IDLE: begin
          if (trig_take) begin
            state   <= ST_HDR;
            hdr_idx <= '0;
          end
        end
        ST_HDR: begin
          hdr_idx <= hdr_idx + 3'd1;
          if (hdr_last) begin
            state    <= ST_SMP;
            cnt      <= '0;
            ovr_next <= 1'b0;
          end
        end
        ST_SMP: begin
          if (trig_take) begin
            state    <= ST_PAD;
            ovr_next <= 1'b1;
          end else if (smp_take) begin
            cnt <= cnt + CW'(1);
            if (last_body) state <= ST_IDLE;
          end
        end
        ST_PAD: begin
          cnt <= cnt + CW'(1);
          if (last_body) begin
            state   <= ST_HDR;
            hdr_idx <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/radar_echo_packer.sv
module radar_echo_packer
  import rep_pkg::*;
#(
  parameter int unsigned LEN_SHORT = 512,
  parameter int unsigned LEN_MED   = 1024,
  parameter int unsigned LEN_LONG  = 2048,
  parameter int unsigned LIMIT     = 65536,
  parameter logic [15:0] SYNC      = 16'hA55A,
  localparam int unsigned MAXLEN = (LEN_SHORT > LEN_MED) ?
                                   ((LEN_SHORT > LEN_LONG) ? LEN_SHORT : LEN_LONG) :
                                   ((LEN_MED > LEN_LONG) ? LEN_MED : LEN_LONG),
  localparam int unsigned MINLEN = (LEN_SHORT < LEN_MED) ?
                                   ((LEN_SHORT < LEN_LONG) ? LEN_SHORT : LEN_LONG) :
                                   ((LEN_MED < LEN_LONG) ? LEN_MED : LEN_LONG),
  localparam int unsigned CW   = $clog2(MAXLEN + 1),
  localparam int unsigned NMAX = LIMIT / (MINLEN + HDR_BYTES),
  localparam int unsigned NW   = $clog2(NMAX + 1),
  localparam int unsigned AW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic          smp_valid,
  input  logic [7:0]    smp_data,
  input  logic [15:0]   az_in,
  input  logic [15:0]   spd_in,
  input  logic [1:0]    mode_in,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          pkt_done,
  output logic [AW-1:0] pkt_bytes
);

  logic          trig_rise;
  logic          trig_take;
  logic          pad_wr;
  trig_info_t    info;
  logic [CW-1:0] plan_len;
  logic [NW-1:0] plan_n;

  rep_trig_latch u_trig (
    .clk     (clk),
    .rst     (rst),
    .trig    (trig),
    .take    (trig_take),
    .az_in   (az_in),
    .spd_in  (spd_in),
    .mode_in (mode_in),
    .rise    (trig_rise),
    .info    (info)
  );

  rep_plan #(
    .LEN_SHORT (LEN_SHORT),
    .LEN_MED   (LEN_MED),
    .LEN_LONG  (LEN_LONG),
    .LIMIT     (LIMIT),
    .CW        (CW),
    .NW        (NW)
  ) u_plan (
    .mode    (info.mode),
    .samples (plan_len),
    .recs    (plan_n)
  );

  rep_core #(
    .CW   (CW),
    .NW   (NW),
    .AW   (AW),
    .SYNC (SYNC)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .trig_rise (trig_rise),
    .info      (info),
    .plan_len  (plan_len),
    .plan_n    (plan_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .trig_take (trig_take),
    .pad_wr    (pad_wr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pkt_done  (pkt_done),
    .pkt_bytes (pkt_bytes)
  );

endmodule

// File: rtl/rep_checks.sv
module rep_checks #(
  parameter int unsigned AW    = 17,
  parameter int unsigned LIMIT = 65536
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          pkt_done,
  input logic [AW-1:0] pkt_bytes,
  input logic          pad_wr
);

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done);

  // R6: completion coincides with a byte write
  a_r6_done_with_write: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> wr_en);

  // R6: byte count is one past the final address
  a_r6_byte_count: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> (pkt_bytes == wr_addr + AW'(1)));

  // R5: back-to-back writes step the address by one
  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && !$past(pkt_done)) |-> (wr_addr == $past(wr_addr) + AW'(1)));

  // R5: a write right after completion starts at address zero
  a_r5_addr_restart: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && $past(pkt_done)) |-> (wr_addr == '0));

  // R5: writes stay inside the packet limit
  a_r5_in_limit: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < int'(LIMIT)));

  // R8: each padding step emits a zero byte
  a_r8_pad_zero: assert property (@(posedge clk) disable iff (rst)
    pad_wr |=> (wr_en && wr_data == 8'h00));

endmodule

bind radar_echo_packer rep_checks #(
  .AW    (AW),
  .LIMIT (LIMIT)
) u_checks (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .pkt_done  (pkt_done),
  .pkt_bytes (pkt_bytes),
  .pad_wr    (pad_wr)
);

// File: tb/radar_echo_packer_test.sv
`timescale 1ns/1ps
module radar_echo_packer_test;

  localparam int LS    = 20;
  localparam int LM    = 12;
  localparam int LL    = 6;
  localparam int LIM   = 128;
  localparam int AW    = $clog2(LIM + 1);
  localparam logic [15:0] SYNCW = 16'hA55A;
  localparam int OPT_NONE   = 0;
  localparam int OPT_STRAY  = 1;
  localparam int OPT_HOLD   = 2;
  localparam int OPT_RETRIG = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          trig;
  logic          smp_valid;
  logic [7:0]    smp_data;
  logic [15:0]   az_in;
  logic [15:0]   spd_in;
  logic [1:0]    mode_in;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          pkt_done;
  logic [AW-1:0] pkt_bytes;

  always #2 clk = ~clk;

  radar_echo_packer #(
    .LEN_SHORT (LS),
    .LEN_MED   (LM),
    .LEN_LONG  (LL),
    .LIMIT     (LIM),
    .SYNC      (SYNCW)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .az_in     (az_in),
    .spd_in    (spd_in),
    .mode_in   (mode_in),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pkt_done  (pkt_done),
    .pkt_bytes (pkt_bytes)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] img     [0:(1<<AW)-1];
  logic [7:0] exp_img [0:(1<<AW)-1];
  int exp_ptr  = 0;
  int owed_pad = 0;
  int nwr = 0, nwr_base = 0;
  int done_cnt = 0, done_base = 0;
  int last_bytes = 0, done_addr = 0, dbl = 0;
  bit prev_done = 1'b0;

  // output monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        img[wr_addr] = wr_data;
        nwr++;
      end
      if (pkt_done) begin
        done_cnt++;
        last_bytes = int'(pkt_bytes);
        done_addr  = int'(wr_addr);
        if (prev_done) dbl++;
      end
      prev_done = pkt_done;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_put(input logic [7:0] b);
    exp_img[exp_ptr] = b;
    exp_ptr++;
  endtask

  function automatic int recs_for(input int len);
    return LIM / (len + 7);
  endfunction

  // one trigger plus its samples; the model records the expected bytes
  task automatic run_record(input logic [15:0] az, input logic [15:0] spd,
                            input logic [1:0] mode, input logic [1:0] pcode,
                            input bit ovr, input int len, input int nsamp,
                            input logic [7:0] base, input int opt);
    int acc;
    exp_put(SYNCW[15:8]);
    exp_put(SYNCW[7:0]);
    exp_put({ovr, 5'b00000, pcode});
    exp_put(az[15:8]);
    exp_put(az[7:0]);
    exp_put(spd[15:8]);
    exp_put(spd[7:0]);
    @(negedge clk);
    az_in = az; spd_in = spd; mode_in = mode; trig = 1'b1;
    @(negedge clk);
    az_in = ~az; spd_in = ~spd;
    if (opt == OPT_HOLD) begin
      cycles(2);
      trig = 1'b0;
    end else begin
      trig = 1'b0;
    end
    if (opt == OPT_RETRIG) begin
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
    end
    if (opt == OPT_STRAY) begin
      smp_data = 8'hEE; smp_valid = 1'b1;
      @(negedge clk); smp_valid = 1'b0;
    end
    cycles(10 + owed_pad);
    for (int i = 0; i < nsamp; i++) begin
      smp_data = base + 8'(i); smp_valid = 1'b1;
      @(negedge clk); smp_valid = 1'b0;
      @(negedge clk);
      if (i < len) exp_put(base + 8'(i));
    end
    acc = (nsamp < len) ? nsamp : len;
    for (int i = acc; i < len; i++) exp_put(8'h00);
    owed_pad = len - acc;
    cycles(2);
  endtask

  task automatic check_pkt(input string req, input int exp_bytes);
    int bad;
    cycles(6);
    check(done_cnt - done_base == 1, "R6", "completion pulses", done_cnt - done_base, 1);
    check(last_bytes == exp_bytes, "R6", "pkt_bytes", last_bytes, exp_bytes);
    check(done_addr == exp_bytes - 1, "R6", "address at completion", done_addr, exp_bytes - 1);
    check(nwr - nwr_base == exp_bytes, "R4", "bytes written", nwr - nwr_base, exp_bytes);
    check(exp_ptr == exp_bytes, req, "model size", exp_ptr, exp_bytes);
    bad = -1;
    for (int i = 0; i < exp_bytes; i++)
      if (bad < 0 && img[i] !== exp_img[i]) bad = i;
    check(bad < 0, req, "packet image first bad byte",
          (bad < 0) ? 0 : int'(img[bad]), (bad < 0) ? 0 : int'(exp_img[bad]));
    done_base = done_cnt;
    nwr_base  = nwr;
    exp_ptr   = 0;
    owed_pad  = 0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cycles(2);
    trig = 1'b1; smp_valid = 1'b1; smp_data = 8'h55;
    cycles(2);
    check(wr_en == 1'b0, "R1", "wr_en in reset", int'(wr_en), 0);
    check(pkt_done == 1'b0, "R1", "pkt_done in reset", int'(pkt_done), 0);
    trig = 1'b0; smp_valid = 1'b0;
    rst = 1'b0;
    cycles(10);
    check(nwr == 0, "R1", "writes after reset", nwr, 0);
    check(done_cnt == 0, "R1", "pulses after reset", done_cnt, 0);
  endtask

  // short mode, with stray, held and repeated triggers and extra samples
  task automatic t_short;
    int n;
    n = recs_for(LS);
    check(n == 4, "R5", "short records per packet", n, 4);
    run_record(16'h1000, 16'h0200, 2'd0, 2'd0, 1'b0, LS, LS, 8'h11, OPT_STRAY);
    run_record(16'h1A2B, 16'h3C4D, 2'd0, 2'd0, 1'b0, LS, LS, 8'h31, OPT_HOLD);
    run_record(16'h2000, 16'h0300, 2'd0, 2'd0, 1'b0, LS, LS, 8'h51, OPT_RETRIG);
    run_record(16'h3000, 16'h0400, 2'd0, 2'd0, 1'b0, LS, LS + 3, 8'h71, OPT_NONE);
    check_pkt("R5", n * (LS + 7));
    check({img[27], img[28]} == SYNCW, "R2", "sync word", int'({img[27], img[28]}), int'(SYNCW));
    check({img[30], img[31]} == 16'h1A2B, "R2", "azimuth", int'({img[30], img[31]}), 16'h1A2B);
    check({img[32], img[33]} == 16'h3C4D, "R2", "speed", int'({img[32], img[33]}), 16'h3C4D);
    check(img[7] == 8'h11, "R4", "first sample after stray", int'(img[7]), 8'h11);
    check(img[34] == 8'h31, "R10", "held trigger record start", int'(img[34]), 8'h31);
    check(img[56] == 8'h00, "R9", "retrigger mode byte", int'(img[56]), 0);
    check(img[61] == 8'h51, "R9", "retrigger first sample", int'(img[61]), 8'h51);
    check(img[107] == 8'h71 + 8'(LS - 1), "R4", "last kept sample",
          int'(img[107]), int'(8'h71 + 8'(LS - 1)));
  endtask

  // medium mode packet, later triggers ask for short mode
  task automatic t_modechg;
    int n;
    n = recs_for(LM);
    run_record(16'h0100, 16'h0010, 2'd1, 2'd1, 1'b0, LM, LM, 8'h21, OPT_NONE);
    for (int r = 1; r < n; r++)
      run_record(16'h0100 + 16'(r), 16'h0010, 2'd0, 2'd1, 1'b0, LM, LM,
                 8'h21 + 8'(r * 16), OPT_NONE);
    check_pkt("R7", n * (LM + 7));
    check(img[3 * 19 + 2] == 8'h01, "R7", "mode byte mid packet", int'(img[59]), 1);
  endtask

  // mode code 3 uses the long length
  task automatic t_long_alias;
    int n;
    n = recs_for(LL);
    for (int r = 0; r < n; r++)
      run_record(16'h4000 + 16'(r), 16'h0020, 2'd3, 2'd3, 1'b0, LL, LL,
                 8'h81 + 8'(r * 8), OPT_NONE);
    check_pkt("R3", n * (LL + 7));
    check(img[2] == 8'h03, "R3", "mode byte code 3", int'(img[2]), 3);
  endtask

  // early triggers: partial record and empty record
  task automatic t_overrun;
    int n;
    n = recs_for(LL);
    run_record(16'h5000, 16'h0030, 2'd2, 2'd2, 1'b0, LL, 2,  8'h91, OPT_NONE);
    run_record(16'h5001, 16'h0031, 2'd2, 2'd2, 1'b1, LL, LL, 8'hA1, OPT_NONE);
    run_record(16'h5002, 16'h0032, 2'd2, 2'd2, 1'b0, LL, LL, 8'hB1, OPT_NONE);
    run_record(16'h5003, 16'h0033, 2'd2, 2'd2, 1'b0, LL, 0,  8'hC1, OPT_NONE);
    for (int r = 4; r < n; r++)
      run_record(16'h5000 + 16'(r), 16'h0030, 2'd2, 2'd2, (r == 4), LL, LL,
                 8'h31 + 8'(r * 8), OPT_NONE);
    check_pkt("R8", n * (LL + 7));
    check({img[9], img[10], img[11], img[12]} == 32'h0, "R8", "zero padding",
          int'({img[9], img[10], img[11], img[12]}), 0);
    check(img[15] == 8'h82, "R8", "overrun flag after cut", int'(img[15]), 8'h82);
    check(img[28] == 8'h02, "R8", "flag clears", int'(img[28]), 8'h02);
    check(img[46] == 8'h00 && img[51] == 8'h00, "R8", "empty record zeros",
          int'(img[46]) + int'(img[51]), 0);
    check(img[54] == 8'h82, "R8", "flag after empty record", int'(img[54]), 8'h82);
  endtask

  initial begin
    rst = 1'b1; trig = 1'b0; smp_valid = 1'b0; smp_data = '0;
    az_in = '0; spd_in = '0; mode_in = '0;
    t_reset();
    t_short();
    t_modechg();
    t_long_alias();
    t_overrun();
    check(dbl == 0, "R6", "multi-cycle completion pulses", dbl, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule